// File: doc/BRIEF.md
# Processor Stop, Halt and Interrupt Sequencer

This block is the control sequencer that sits beside the datapath of a 4-bit processor. The processor's instruction cycle has eight phases: A1, A2, A3, M1, M2, X1, X2 and X3. The sequencer owns the phase counter, which advances one phase for each strobe. It samples two asynchronous requests, a stop request and an interrupt request, and decides at instruction boundaries whether the processor runs normally, sits in a stop loop, or is steered into an interrupt entry. It drives the controls that do this: force a no-op, force a jump to subroutine at location 3, hold the program counter, and block the data input buffers. It also drives the two acknowledge outputs.

The controlling state machine has five states. RUN is normal execution. STOPPED is the stop loop entered from the stop request. HALTED is the stop loop entered from the halt instruction. JMS1 and JMS2 are the two forced cycles of the interrupt entry. The transitions are as follows:
- RUN to STOPPED at a boundary A1 when the stop request is latched.
- RUN to JMS1 at a boundary A1 when an interrupt is accepted.
- RUN to HALTED at X3 of a halt instruction.
- STOPPED to RUN at X3 of a cycle whose latch saw the stop request low.
- HALTED to STOPPED at A1 when the stop request is latched.
- HALTED to JMS1 at A1 when an interrupt is accepted.
- JMS1 to JMS2 at the next A1.
- JMS2 to RUN at the following A1.

Besides this machine, an interrupt gate holds three pieces of state: the interrupt enable, the acknowledge, and a countdown that runs after a bank switch.

Top module: `cpu_hold_seq`

## Requirements
- R1: After reset, phase_o is A1 (code 0), both acknowledges are low, every forcing control is low, and interrupts are disabled.
- R2: phase_o steps through the codes A1=0, A2=1, A3=2, M1=3, M2=4, X1=5, X2=6, X3=7 and back to 0, one step per clock with ph_step high. It holds its value, and no state changes, while ph_step is low.
- R3: Each request passes through a two-flop synchronizer and is latched on the step into M2. A latched stop enters STOPPED on the step into the next A1 that starts an instruction. When two_cycle_i is high at that step, the next cycle is the second half of a double-cycle instruction, and entry waits one more cycle.
- R4: While STOPPED or HALTED, stop_ack_o, force_nop_o and inh_inc_o are high. inh_din_o is high only in phases M1 and M2.
- R5: In STOPPED, when the latch captured the stop request low, the machine returns to RUN on the step into X3 of that same cycle.
- R6: A halt strobe at the step into X3 raises stop_ack_o (HALTED). HALTED persists while the stop request stays low. A latched stop request moves it to STOPPED at the next A1, and STOPPED then releases as in R5.
- R7: On interrupt entry, force_jms_o and inh_inc_o are high for two full cycles, and inh_din_o is high in M1 and M2 of those cycles. int_ack_o rises on the step into X3 of the first forced cycle.
- R8: int_ack_o stays high until a return strobe (bbs_i) at the step into X3. While int_ack_o is high, no interrupt entry happens.
- R9: When both requests are latched in the same M2, STOPPED is entered. The interrupt is taken at the first boundary after STOPPED is released.
- R10: Interrupts are ignored until an enable strobe. A disable strobe makes them ignored again.
- R11: A bank-switch strobe (db0_i or db1_i) blocks interrupt entry at the next three instruction boundaries. Entry is possible at the fourth.
- R12: An accepted interrupt leaves HALTED directly for JMS1, and stop_ack_o falls at that A1.
- R13: The decoded strobes (hlt, bbs, ein, din, db0, db1) act only in RUN and are ignored in any other state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_step | input | 1 | Phase advance strobe |
| two_cycle_i | input | 1 | Current cycle is the first half of a double-cycle instruction (sampled on the step into A1) |
| stop_req_i | input | 1 | Asynchronous stop request |
| int_req_i | input | 1 | Asynchronous interrupt request |
| hlt_i | input | 1 | Decoded halt instruction |
| bbs_i | input | 1 | Decoded return-from-interrupt instruction |
| ein_i | input | 1 | Decoded interrupt enable |
| din_i | input | 1 | Decoded interrupt disable |
| db0_i | input | 1 | Decoded bank switch to bank 0 |
| db1_i | input | 1 | Decoded bank switch to bank 1 |
| phase_o | output | 3 | Current phase code |
| stop_ack_o | output | 1 | Stop acknowledge |
| int_ack_o | output | 1 | Interrupt acknowledge |
| force_nop_o | output | 1 | Replace the fetched instruction with a no-op |
| force_jms_o | output | 1 | Replace the fetched instruction with a jump to subroutine at location 3 |
| inh_inc_o | output | 1 | Hold the program counter |
| inh_din_o | output | 1 | Block the data input buffers |

## Verification
The bench places a stop request against a double-cycle instruction. A design that looked only at the phase, and not at the instruction boundary, would stop one cycle early. The bench also latches both requests in the same cycle, where a design with the priority reversed would force the jump first. It checks that a halt survives a low stop request, which a design that treated halt as plain stop would drop at X3. It counts the three boundaries after a bank switch, catching a countdown off by one either way, and it sends strobes during halt that a design without RUN gating would obey. The bench also stalls the phase strobe at X3 with a stop pending, so any transition not tied to the strobe shows up.

// File: rtl/cpu_hold_seq_pkg.sv
package cpu_hold_seq_pkg;
    typedef enum logic [2:0] {
        PH_A1 = 3'd0, PH_A2 = 3'd1, PH_A3 = 3'd2, PH_M1 = 3'd3,
        PH_M2 = 3'd4, PH_X1 = 3'd5, PH_X2 = 3'd6, PH_X3 = 3'd7
    } phase_e;

    typedef enum logic [2:0] {
        MD_RUN  = 3'd0,
        MD_STOP = 3'd1,
        MD_HALT = 3'd2,
        MD_JMS1 = 3'd3,
        MD_JMS2 = 3'd4
    } mode_e;
endpackage

// File: rtl/seq_phase_ctr.sv
module seq_phase_ctr
    import cpu_hold_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step,
    output phase_e phase,
    output logic   a1_ent,
    output logic   m2_ent,
    output logic   x3_ent
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= PH_A1;
        else if (step)
            phase <= phase_e'(phase + 3'd1);
    end

    assign a1_ent = step && (phase == PH_X3);
    assign m2_ent = step && (phase == PH_M1);
    assign x3_ent = step && (phase == PH_X2);

    // R2: no phase movement without a strobe
    a_r2_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(step)) |-> $stable(phase));
endmodule

// File: rtl/seq_req_sampler.sv
module seq_req_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    input  logic capture,
    output logic lat_o
);
    logic [STAGES-1:0] sync_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    sync_q[g] <= 1'b0;
                else if (g == 0)
                    sync_q[g] <= async_i;
                else
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lat_o <= 1'b0;
        else if (capture)
            lat_o <= sync_q[STAGES-1];
    end

    // R3: the latch only moves on the M2 capture strobe
    a_r3_latch_at_m2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(capture)) |-> $stable(lat_o));
endmodule

// File: rtl/seq_irq_gate.sv
module seq_irq_gate #(
    parameter int HOLD_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a1_ent,
    input  logic x3_ent,
    input  logic ein,
    input  logic din,
    input  logic bank_sw,
    input  logic bbs,
    input  logic set_ack,
    output logic ie_o,
    output logic ack_o,
    output logic blocked_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYCLES);

    logic [CW-1:0] hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_o     <= 1'b0;
            ack_o    <= 1'b0;
            hold_cnt <= '0;
        end else begin
            if (x3_ent && ein)
                ie_o <= 1'b1;
            else if (x3_ent && din)
                ie_o <= 1'b0;

            if (set_ack)
                ack_o <= 1'b1;
            else if (x3_ent && bbs)
                ack_o <= 1'b0;

            if (x3_ent && bank_sw)
                hold_cnt <= HOLD_LD;
            else if (a1_ent && hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign blocked_o = (hold_cnt != '0);

    // R8: acknowledge only clears through a return strobe at X3
    a_r8_ack_clear_path: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> $past(x3_ent && bbs));
endmodule

// File: rtl/cpu_hold_seq.sv
module cpu_hold_seq
    import cpu_hold_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BANK_HOLD   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ph_step,
    input  logic       two_cycle_i,
    input  logic       stop_req_i,
    input  logic       int_req_i,
    input  logic       hlt_i,
    input  logic       bbs_i,
    input  logic       ein_i,
    input  logic       din_i,
    input  logic       db0_i,
    input  logic       db1_i,
    output logic [2:0] phase_o,
    output logic       stop_ack_o,
    output logic       int_ack_o,
    output logic       force_nop_o,
    output logic       force_jms_o,
    output logic       inh_inc_o,
    output logic       inh_din_o
);
    phase_e phase;
    logic   a1_ent, m2_ent, x3_ent;
    logic   stop_lat, int_lat;
    logic   ie, blocked;
    mode_e  mode, mode_n;
    logic   second_half, second_half_n;
    logic   exec_ok, int_ok, set_ack;

    seq_phase_ctr u_phase (
        .clk(clk), .rst_n(rst_n), .step(ph_step), .phase(phase),
        .a1_ent(a1_ent), .m2_ent(m2_ent), .x3_ent(x3_ent)
    );

    seq_req_sampler #(.STAGES(SYNC_STAGES)) u_stop_smp (
        .clk(clk), .rst_n(rst_n), .async_i(stop_req_i),
        .capture(m2_ent), .lat_o(stop_lat)
    );

    seq_req_sampler #(.STAGES(SYNC_STAGES)) u_int_smp (
        .clk(clk), .rst_n(rst_n), .async_i(int_req_i),
        .capture(m2_ent), .lat_o(int_lat)
    );

    assign exec_ok = (mode == MD_RUN);
    assign set_ack = x3_ent && (mode == MD_JMS1);

    seq_irq_gate #(.HOLD_CYCLES(BANK_HOLD)) u_gate (
        .clk(clk), .rst_n(rst_n), .a1_ent(a1_ent), .x3_ent(x3_ent),
        .ein(ein_i && exec_ok), .din(din_i && exec_ok),
        .bank_sw((db0_i || db1_i) && exec_ok), .bbs(bbs_i && exec_ok),
        .set_ack(set_ack), .ie_o(ie), .ack_o(int_ack_o), .blocked_o(blocked)
    );

    assign int_ok        = int_lat && ie && !int_ack_o && !blocked;
    assign second_half_n = exec_ok && !second_half && two_cycle_i;

    // next-state logic
    always_comb begin
        mode_n = mode;
        unique case (mode)
            MD_RUN: begin
                if (a1_ent && !second_half_n) begin
                    if (stop_lat)    mode_n = MD_STOP;
                    else if (int_ok) mode_n = MD_JMS1;
                end else if (x3_ent && hlt_i) begin
                    mode_n = MD_HALT;
                end
            end
            MD_STOP: begin
                if (x3_ent && !stop_lat) mode_n = MD_RUN;
            end
            MD_HALT: begin
                if (a1_ent) begin
                    if (stop_lat)    mode_n = MD_STOP;
                    else if (int_ok) mode_n = MD_JMS1;
                end
            end
            MD_JMS1: begin
                if (a1_ent) mode_n = MD_JMS2;
            end
            MD_JMS2: begin
                if (a1_ent) mode_n = MD_RUN;
            end
            default: mode_n = MD_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode        <= MD_RUN;
            second_half <= 1'b0;
        end else begin
            mode <= mode_n;
            if (a1_ent)
                second_half <= second_half_n;
        end
    end

    // outputs
    always_comb begin
        force_nop_o = 1'b0;
        force_jms_o = 1'b0;
        unique case (mode)
            MD_STOP, MD_HALT: force_nop_o = 1'b1;
            MD_JMS1, MD_JMS2: force_jms_o = 1'b1;
            default: ;
        endcase
        stop_ack_o = force_nop_o;
        inh_inc_o  = force_nop_o || force_jms_o;
        inh_din_o  = inh_inc_o && (phase == PH_M1 || phase == PH_M2);
        phase_o    = phase;
    end

    // R7: acknowledge rises only at X3
    a_r7_ack_rise_x3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_ack_o) |-> (phase == PH_X3));
    // R8: no new entry while acknowledge held
    a_r8_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_jms_o) |-> !$past(int_ack_o));
    // R4: stop loop and interrupt entry never overlap
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(force_nop_o && force_jms_o));
    // R3: stop acknowledge rises only at A1 (request) or X3 (halt)
    a_r3_stop_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_ack_o) |-> (phase == PH_A1 || phase == PH_X3));
    // R4: input blocking confined to M1 and M2
    a_r4_din_window: assert property (@(posedge clk) disable iff (!rst_n)
        inh_din_o |-> (phase == PH_M1 || phase == PH_M2));
endmodule

// File: tb/cpu_hold_seq_tb.sv
module cpu_hold_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ph_step = 1'b0, two_cycle_i = 1'b0, stop_req_i = 1'b0, int_req_i = 1'b0;
    logic hlt_i = 1'b0, bbs_i = 1'b0, ein_i = 1'b0, din_i = 1'b0, db0_i = 1'b0, db1_i = 1'b0;
    logic [2:0] phase_o;
    logic stop_ack_o, int_ack_o, force_nop_o, force_jms_o, inh_inc_o, inh_din_o;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [2:0] A1 = 3'd0, M1 = 3'd3, X2 = 3'd6, X3 = 3'd7;

    always #2 clk = ~clk;

    cpu_hold_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ph_step(ph_step), .two_cycle_i(two_cycle_i),
        .stop_req_i(stop_req_i), .int_req_i(int_req_i), .hlt_i(hlt_i), .bbs_i(bbs_i),
        .ein_i(ein_i), .din_i(din_i), .db0_i(db0_i), .db1_i(db1_i),
        .phase_o(phase_o), .stop_ack_o(stop_ack_o), .int_ack_o(int_ack_o),
        .force_nop_o(force_nop_o), .force_jms_o(force_jms_o),
        .inh_inc_o(inh_inc_o), .inh_din_o(inh_din_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_to(input logic [2:0] p);
        while (phase_o != p) tick();
    endtask

    task automatic to_next_a1();
        run_to(X3);
        tick();
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) to_next_a1();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ph_step = 1'b0;
        {two_cycle_i, stop_req_i, int_req_i, hlt_i, bbs_i, ein_i, din_i, db0_i, db1_i} = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ph_step = 1'b1;
    endtask

    task automatic pulse_ein();
        run_to(X2); ein_i = 1'b1; tick(); ein_i = 1'b0;
    endtask

    task automatic pulse_hlt();
        run_to(X2); hlt_i = 1'b1; tick(); hlt_i = 1'b0;
    endtask

    task automatic finish_int(input string req);
        int_req_i = 1'b0;
        cycles(3);
        run_to(X2); bbs_i = 1'b1; tick(); bbs_i = 1'b0;
        chk({req, " ack cleared by return"}, int_ack_o, 0);
        to_next_a1();
    endtask

    task automatic t_reset_and_phase();
        do_reset();
        chk("R1 phase", phase_o, 0);
        chk("R1 acks", {stop_ack_o, int_ack_o}, 0);
        chk("R1 controls", {force_nop_o, force_jms_o, inh_inc_o, inh_din_o}, 0);
        for (int i = 1; i <= 8; i++) begin
            tick();
            chk("R2 phase order", phase_o, i % 8);
        end
        int_req_i = 1'b1;
        cycles(3);
        chk("R10 disabled after reset", force_jms_o, 0);
        int_req_i = 1'b0;
        cycles(2);
    endtask

    task automatic t_stop_single();
        stop_req_i = 1'b1;
        run_to(X3);
        chk("R3 no stop before boundary", stop_ack_o, 0);
        ph_step = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 phase held", phase_o, X3);
        chk("R2 no entry while stalled", stop_ack_o, 0);
        ph_step = 1'b1;
        tick();
        chk("R3 stop at A1", stop_ack_o, 1);
        chk("R4 nop/inc", {force_nop_o, inh_inc_o}, 2'b11);
        chk("R4 din outside M", inh_din_o, 0);
        run_to(M1);
        chk("R4 din in M1", inh_din_o, 1);
        to_next_a1();
        stop_req_i = 1'b0;
        run_to(X2);
        chk("R5 still stopped at X2", stop_ack_o, 1);
        tick();
        chk("R5 released at X3", stop_ack_o, 0);
        tick();
    endtask

    task automatic t_stop_double();
        two_cycle_i = 1'b1;
        stop_req_i = 1'b1;
        to_next_a1();
        two_cycle_i = 1'b0;
        chk("R3 deferred by double cycle", stop_ack_o, 0);
        to_next_a1();
        chk("R3 entered after second half", stop_ack_o, 1);
        stop_req_i = 1'b0;
        to_next_a1();
    endtask

    task automatic t_halt_stop_exit();
        pulse_hlt();
        chk("R6 halt at X3", stop_ack_o, 1);
        cycles(3);
        chk("R6 halt persists", stop_ack_o, 1);
        stop_req_i = 1'b1;
        to_next_a1();
        to_next_a1();
        chk("R6 still held in stop", stop_ack_o, 1);
        stop_req_i = 1'b0;
        run_to(X3);
        chk("R6 stop releases after conversion", stop_ack_o, 0);
        tick();
    endtask

    task automatic t_interrupt();
        pulse_ein();
        to_next_a1();
        int_req_i = 1'b1;
        to_next_a1();
        chk("R7 forced jms", force_jms_o, 1);
        chk("R7 inc held", inh_inc_o, 1);
        run_to(M1);
        chk("R7 din blocked", inh_din_o, 1);
        run_to(X2);
        chk("R7 ack not yet", int_ack_o, 0);
        tick();
        chk("R7 ack at X3", int_ack_o, 1);
        tick();
        chk("R7 second forced cycle", force_jms_o, 1);
        to_next_a1();
        chk("R7 forced cycles done", force_jms_o, 0);
        cycles(2);
        chk("R8 no reentry while ack", force_jms_o, 0);
        chk("R8 ack held", int_ack_o, 1);
        finish_int("R8");
    endtask

    task automatic t_priority();
        stop_req_i = 1'b1;
        int_req_i = 1'b1;
        to_next_a1();
        chk("R9 stop wins", {stop_ack_o, force_jms_o}, 2'b10);
        stop_req_i = 1'b0;
        to_next_a1();
        chk("R9 interrupt after stop clears", force_jms_o, 1);
        finish_int("R9");
    endtask

    task automatic t_disable();
        run_to(X2); din_i = 1'b1; tick(); din_i = 1'b0;
        int_req_i = 1'b1;
        cycles(3);
        chk("R10 disabled by din", force_jms_o, 0);
        int_req_i = 1'b0;
        cycles(2);
        pulse_ein();
        tick();
    endtask

    task automatic t_bank_hold();
        run_to(A1);
        int_req_i = 1'b1;
        run_to(X2); db1_i = 1'b1; tick(); db1_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R11 blocked boundary", force_jms_o, 0);
            run_to(X3);
        end
        tick();
        chk("R11 fourth boundary accepts", force_jms_o, 1);
        finish_int("R11");
    endtask

    task automatic t_halt_int_exit();
        pulse_hlt();
        cycles(2);
        int_req_i = 1'b1;
        to_next_a1();
        chk("R12 halt exit via interrupt", {stop_ack_o, force_jms_o}, 2'b01);
        finish_int("R12");
    endtask

    task automatic t_strobes_ignored();
        do_reset();
        pulse_hlt();
        run_to(X2); ein_i = 1'b1; tick(); ein_i = 1'b0;
        int_req_i = 1'b1;
        cycles(3);
        chk("R13 ein ignored while halted", {stop_ack_o, force_jms_o}, 2'b10);
        int_req_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_and_phase();
        t_stop_single();
        t_stop_double();
        t_halt_stop_exit();
        t_interrupt();
        t_priority();
        t_disable();
        t_bank_hold();
        t_halt_int_exit();
        t_strobes_ignored();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule